// File: doc/BRIEF.md
# Three-Valued Logic Vector Unit

This block evaluates strong three-valued logic over two vectors of digits that can each be false, unknown or true, ordered false < unknown < true. Every digit lane is computed on its own and in parallel: the operation select picks one of negation, minimum (conjunction), maximum (disjunction), implication or exclusive-or. The derived operators are built only from negation, minimum and maximum over that order. Because of this, each one falls back to its ordinary two-valued meaning whenever the inputs hold only false and true.

The combinational result feeds a register that works as a D-type store for the whole vector. When the input strobe is high, the register captures the result on the clock edge and raises its valid output one cycle later. It holds its contents while the strobe is low. Digit codes that are not legal and operation codes that are not defined are detected. They turn the affected result digits to unknown and set an error flag that stays set until reset.

Top module: `tern_logic_unit`

## Requirements
- R1: Each digit is carried on two bits as false=2'b00, unknown=2'b01, true=2'b10; 2'b11 is illegal and the result never contains 2'b11.
- R2: Select 3'b000 negates operand A digit by digit (false and true swap, unknown stays); operand B is ignored, and an illegal code in B neither alters the result nor sets the error flag.
- R3: Select 3'b001 gives per-digit minimum of A and B.
- R4: Select 3'b010 gives per-digit maximum of A and B.
- R5: Select 3'b011 gives implication, max(neg(A), B), per digit.
- R6: Select 3'b100 gives exclusive-or, max(min(neg(A),B), min(A,neg(B))); any unknown input digit yields unknown.
- R7: With only false/true digits, selects 001, 010, 011 and 100 match Boolean AND, OR, implication and XOR.
- R8: An illegal code in a digit of an operand in use makes that result digit unknown, leaves the other digits correct, and sets the error flag when loaded.
- R9: Select codes 3'b101 to 3'b111 produce an all-unknown result and set the error flag when loaded.
- R10: The result register loads when in_valid is high at a rising edge; res_valid is high exactly in the cycle after a load; res holds while in_valid is low.
- R11: The error flag is sticky until reset; the asynchronous active-low reset clears res to all-unknown and clears res_valid and err.
- R12: Digit lanes are independent: each result digit depends only on the same-position digits of A and B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load strobe for the result register |
| op_sel | input | 3 | Operation select |
| opa | input | 2*N | Operand A, digit i at bits [2i+1:2i] |
| opb | input | 2*N | Operand B, digit i at bits [2i+1:2i] |
| res | output | 2*N | Registered result vector |
| res_valid | output | 1 | High in the cycle after a load |
| err | output | 1 | Sticky illegal-code flag |

## Verification
The clocked properties assume that in_valid, op_sel and the operands are settled before each rising edge. They also assume that reset is released away from an edge. The bench meets both conditions by driving every input on the falling edge and sampling one falling edge later. The lane checks assume that legal digits never carry code 2'b11. The bench therefore introduces illegal codes only in dedicated error cases, one lane at a time, and confirms that the other lanes still match the reference. The legal sweep places all nine digit pairs in every lane through rotation, for every defined operation.

// File: rtl/tern_pkg.sv
package tern_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TR_F   = 2'b00;
  localparam trit_t TR_U   = 2'b01;
  localparam trit_t TR_T   = 2'b10;
  localparam trit_t TR_BAD = 2'b11;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NEG = 3'd0,
    OP_MIN = 3'd1,
    OP_MAX = 3'd2,
    OP_IMP = 3'd3,
    OP_XOR = 3'd4
  } op_e;

  typedef struct packed {
    logic do_neg;
    logic do_min;
    logic do_max;
    logic do_imp;
    logic do_xor;
  } op_dec_t;

  // Order-based primitives; legal codes are numerically ordered.
  function automatic trit_t t_neg(input trit_t a);
    return trit_t'(TR_T - a);
  endfunction

  function automatic trit_t t_min(input trit_t a, input trit_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic trit_t t_max(input trit_t a, input trit_t b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tern_op_decode.sv
module tern_op_decode
  import tern_pkg::*;
(
  input  logic [OP_W-1:0] op_sel,
  output op_dec_t         dec,
  output logic            op_bad
);

  always_comb begin
    dec = '0;
    unique case (op_sel)
      OP_NEG:  dec.do_neg = 1'b1;
      OP_MIN:  dec.do_min = 1'b1;
      OP_MAX:  dec.do_max = 1'b1;
      OP_IMP:  dec.do_imp = 1'b1;
      OP_XOR:  dec.do_xor = 1'b1;
      default: dec = '0;
    endcase
  end

  assign op_bad = (op_sel > OP_XOR);

  // R9: an undefined select enables no operator; a defined one enables exactly one
  always_comb begin
    a_r9_dec_onehot: assert ($onehot0(dec) && (op_bad == (dec == '0)));
  end

endmodule

// File: rtl/tern_trit_eval.sv
module tern_trit_eval
  import tern_pkg::*;
(
  input  op_dec_t dec,
  input  trit_t   a,
  input  trit_t   b,
  output trit_t   y,
  output logic    bad
);

  logic  a_bad, b_bad;
  trit_t na, nb, r_min, r_max, r_imp, r_xor;
  trit_t y_calc;

  assign a_bad = (a == TR_BAD);
  assign b_bad = (b == TR_BAD) && !dec.do_neg;
  assign bad   = a_bad || b_bad;

  assign na    = t_neg(a);
  assign nb    = t_neg(b);
  assign r_min = t_min(a, b);
  assign r_max = t_max(a, b);
  assign r_imp = t_max(na, b);
  assign r_xor = t_max(t_min(na, b), t_min(a, nb));

  always_comb begin
    y_calc = TR_U;
    if (dec.do_neg)      y_calc = na;
    else if (dec.do_min) y_calc = r_min;
    else if (dec.do_max) y_calc = r_max;
    else if (dec.do_imp) y_calc = r_imp;
    else if (dec.do_xor) y_calc = r_xor;
  end

  assign y = bad ? TR_U : y_calc;

  // R1: a lane never emits the illegal code
  always_comb begin
    a_r1_no_bad_code: assert (y != TR_BAD);
  end

  // R8: a flagged lane always reads unknown
  always_comb begin
    a_r8_bad_lane_unknown: assert (!bad || (y == TR_U));
  end

endmodule

// File: rtl/tern_result_reg.sv
module tern_result_reg
  import tern_pkg::*;
#(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         bad_in,
  output logic [W-1:0] q,
  output logic         q_valid,
  output logic         err
);

  localparam logic [W-1:0] ALL_U = {N{TR_U}};

  logic [W-1:0] q_nxt;
  logic         err_nxt;

  always_comb begin
    q_nxt   = q;
    err_nxt = err;
    if (load) begin
      q_nxt = d;
      if (bad_in) err_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= ALL_U;
      q_valid <= 1'b0;
      err     <= 1'b0;
    end else begin
      q       <= q_nxt;
      q_valid <= load;
      err     <= err_nxt;
    end
  end

  a_r10_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);

  a_r10_valid_only_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !q_valid);

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r11_err_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!err && !(load && bad_in)) |=> !err);

endmodule

// File: rtl/tern_logic_unit.sv
module tern_logic_unit
  import tern_pkg::*;
#(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  output logic [W-1:0]    res,
  output logic            res_valid,
  output logic            err
);

  op_dec_t      dec;
  logic         op_bad;
  logic [N-1:0] lane_bad;
  logic [W-1:0] comb_res;
  logic         any_bad;

  tern_op_decode u_dec (
    .op_sel (op_sel),
    .dec    (dec),
    .op_bad (op_bad)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    tern_trit_eval u_lane (
      .dec (dec),
      .a   (opa[2*i +: 2]),
      .b   (opb[2*i +: 2]),
      .y   (comb_res[2*i +: 2]),
      .bad (lane_bad[i])
    );
  end

  assign any_bad = op_bad || (|lane_bad);

  tern_result_reg #(.N(N)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d       (comb_res),
    .bad_in  (any_bad),
    .q       (res),
    .q_valid (res_valid),
    .err     (err)
  );

  a_r9_undefined_op_all_u: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel > OP_XOR)) |=> ((res == {N{TR_U}}) && err));

  a_r8_err_on_bad_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|lane_bad)) |=> err);

endmodule

// File: tb/tern_logic_unit_test.sv
module tern_logic_unit_test;

  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   op_sel;
  logic [W-1:0] opa, opb;
  logic [W-1:0] res;
  logic         res_valid, err;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  always #10 clk = ~clk;  // 50 MHz

  tern_logic_unit #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .res(res), .res_valid(res_valid), .err(err)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Reference from the value order F(0) < U(1) < T(2), independent case forms
  function automatic logic [1:0] ref_trit(input int op, input logic [1:0] a, input logic [1:0] b);
    if (op == 0) return (a == 2'b00) ? 2'b10 : (a == 2'b10) ? 2'b00 : 2'b01;
    if (op == 1) return (a <= b) ? a : b;
    if (op == 2) return (a >= b) ? a : b;
    if (op == 3) begin
      if (a == 2'b00 || b == 2'b10) return 2'b10;
      if (a == 2'b10) return b;
      return 2'b01;
    end
    if (op == 4) begin
      if (a == 2'b01 || b == 2'b01) return 2'b01;
      return (a != b) ? 2'b10 : 2'b00;
    end
    return 2'b01;
  endfunction

  function automatic logic [1:0] pair_a(input int k); return 2'(k / 3); endfunction
  function automatic logic [1:0] pair_b(input int k); return 2'(k % 3); endfunction

  // Drive on a falling edge, load on the next rising edge, sample on the next falling edge
  task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    op_sel = op; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [W-1:0] a, b, exp;
    logic [W-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset res all-U", res, {N{2'b01}});
    chk1("R11 reset res_valid", res_valid, 1'b0);
    chk1("R11 reset err", err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R10 no valid without load", res_valid, 1'b0);

    // R2..R6, R12, R1: all nine pairs in every lane via rotation
    for (int op = 0; op < 5; op++) begin
      for (int rot = 0; rot < 9; rot++) begin
        for (int i = 0; i < N; i++) begin
          int k = (i + rot) % 9;
          a[2*i +: 2]   = pair_a(k);
          b[2*i +: 2]   = pair_b(k);
          exp[2*i +: 2] = ref_trit(op, pair_a(k), pair_b(k));
        end
        apply(3'(op), a, b);
        case (op)
          0: chk("R2 negation sweep", res, exp);
          1: chk("R3 minimum sweep", res, exp);
          2: chk("R4 maximum sweep", res, exp);
          3: chk("R5 implication sweep", res, exp);
          default: chk("R6 xor sweep R12 lanes", res, exp);
        endcase
        chk1("R10 valid after load", res_valid, 1'b1);
      end
    end
    chk1("R1 legal sweep leaves err low", err, 1'b0);

    // R7: Boolean reduction with false/true digits only
    for (int x = 0; x < 256; x += 37) begin
      for (int y = 5; y < 256; y += 51) begin
        logic [7:0] xa = 8'(x), yb = 8'(y);
        logic [7:0] bo;
        for (int i = 0; i < N; i++) begin
          a[2*i +: 2] = xa[i % 8] ? 2'b10 : 2'b00;
          b[2*i +: 2] = yb[i % 8] ? 2'b10 : 2'b00;
        end
        for (int op = 1; op < 5; op++) begin
          bo = (op == 1) ? (xa & yb) : (op == 2) ? (xa | yb) :
               (op == 3) ? (~xa | yb) : (xa ^ yb);
          for (int i = 0; i < N; i++) exp[2*i +: 2] = bo[i % 8] ? 2'b10 : 2'b00;
          apply(3'(op), a, b);
          chk("R7 boolean reduction", res, exp);
        end
      end
    end

    // R10: hold while in_valid low, inputs changing
    held = res;
    op_sel = 3'd2; opa = {N{2'b10}}; opb = {N{2'b10}};
    repeat (3) @(negedge clk);
    chk("R10 hold while idle", res, held);
    chk1("R10 valid low while idle", res_valid, 1'b0);

    // R2: illegal B ignored under negation
    a = {N{2'b00}}; b = {N{2'b11}};
    apply(3'd0, a, b);
    chk("R2 negation ignores B", res, {N{2'b10}});
    chk1("R2 illegal B no err", err, 1'b0);

    // R8: illegal digit in lane 3 of A under min
    a = {N{2'b10}}; a[7:6] = 2'b11; b = {N{2'b10}};
    exp = {N{2'b10}}; exp[7:6] = 2'b01;
    apply(3'd1, a, b);
    chk("R8 bad lane unknown others intact", res, exp);
    chk1("R8 err set", err, 1'b1);

    // R11: sticky across a clean load
    apply(3'd2, {N{2'b00}}, {N{2'b10}});
    chk("R11 clean load after error", res, {N{2'b10}});
    chk1("R11 err sticky", err, 1'b1);

    // R11: asynchronous reset clears everything
    rst_n = 1'b0;
    #3;
    chk("R11 reset clears res", res, {N{2'b01}});
    chk1("R11 reset clears err", err, 1'b0);
    chk1("R11 reset clears valid", res_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: undefined select codes
    for (int op = 5; op < 8; op++) begin
      apply(3'(op), {N{2'b10}}, {N{2'b00}});
      chk("R9 undefined op all-U", res, {N{2'b01}});
      chk1("R9 undefined op err", err, 1'b1);
    end

    // R8: illegal B under xor in lane 0, after fresh reset
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    a = {N{2'b10}}; b = {N{2'b00}}; b[1:0] = 2'b11;
    exp = {N{2'b10}}; exp[1:0] = 2'b01;
    apply(3'd4, a, b);
    chk("R8 bad B lane xor", res, exp);
    chk1("R8 err from B", err, 1'b1);

    report();
  end

endmodule